// File: doc/BRIEF.md
# Page-offset-indexed, physically-tagged L1 data cache lookup

This block is the load/store lookup path of a small first-level data cache. The set is chosen only from address bits that lie inside the page offset. Those bits are the same before and after address translation, so the tag and data arrays are read in the same cycle that an external translation unit returns the physical frame number. The stored tags are physical. Each valid way's tag is compared against the upper bits of the physical address, which are formed from the frame number and the page offset. The result is a hit or a miss within the accepting cycle.

A read miss fetches the whole block from memory through a simple burst read port and writes it into the victim way. The block then answers the original read. Writes go straight through to memory. A write hit also patches the cached word. A write miss leaves the cache untouched.

The only way to grow capacity past one page per way is to add ways. Because tags are physical, a change of address-space context needs no flush.

Top module: `vipt_l1_lookup`

## Requirements
- R1: The set index is req_voff[OFF_W+IDX_W-1:OFF_W], where IDX_W = log2(CACHE_BYTES/(BLOCK_BYTES*WAYS)) and OFF_W = log2(BLOCK_BYTES). Elaboration fails if IDX_W+OFF_W exceeds the page-offset width. Two offsets in the same block with the same frame reach the same line.
- R2: While req_valid is high and xlat_valid is low, the request is stalled. xlat_stall is 1 and req_ready is 0. No response and no memory traffic result. The request is accepted once xlat_valid rises.
- R3: A read is accepted when req_valid and req_ready are both high. It hits when a valid way's stored physical tag equals the upper physical address bits. The hit answers on the next cycle with resp_valid=1, resp_hit=1 and the stored word.
- R4: One cycle after a read miss is accepted, mem_rd_req pulses for one cycle. mem_rd_addr is the block-aligned physical address {frame, page offset with the low OFF_W bits cleared}. The memory returns BLOCK_BYTES/4 words in ascending order, one per mem_rd_valid cycle. The cycle after the last word, resp_valid=1, resp_hit=0 and resp_rdata holds the requested word. Later reads of that block hit.
- R5: Each set keeps a marker of its most recently used way, updated on every hit and every refill. The victim is marker+1 modulo WAYS. With two ways this is least-recently-used replacement.
- R6: One cycle after a write is accepted, mem_wr_en pulses for one cycle. mem_wr_addr carries the physical byte address and mem_wr_data carries the data. On a write hit the cached word is updated and resp_hit=1.
- R7: A write miss gives resp_hit=0. It starts no refill and does not change the replacement markers. A following read of that block misses.
- R8: A lookup with a different frame number for the same page offset misses. It leaves other lines intact, so no flush is needed when the context changes.
- R9: Reset clears every valid bit and marker. While reset is applied, resp_valid, mem_rd_req, mem_wr_en and req_ready are all 0.
- R10: While a refill is in progress, req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_voff | input | PAGE_W | Page-offset bits of the virtual address |
| req_wdata | input | DW | Write data |
| xlat_valid | input | 1 | Translation result is valid this cycle |
| xlat_pfn | input | PA_W-PAGE_W | Physical frame number from translation |
| xlat_stall | output | 1 | Request held for lack of translation |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response was a cache hit |
| resp_rdata | output | DW | Read data of the response |
| mem_rd_req | output | 1 | One-cycle block read request |
| mem_rd_addr | output | PA_W | Block-aligned physical address |
| mem_rd_valid | input | 1 | Refill word present |
| mem_rd_data | input | DW | Refill word |
| mem_wr_en | output | 1 | One-cycle write-through pulse |
| mem_wr_addr | output | PA_W | Physical byte address of the write |
| mem_wr_data | output | DW | Write-through data |

## Verification
Replacement order is the hardest behaviour to observe from the ports, because the chosen way is never visible. The stimulus fills both ways of one set with two frames. It then touches one frame to make it recent and brings in a third frame. Hits and misses on the earlier frames show which way was evicted, and a second round repeats this with the roles reversed. The stall case is reached by holding a request with the translation flag low for several cycles before raising it.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } vipt_state_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int TAG_W = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (sel) begin
        vld_q[wr_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_mem[wr_idx] <= wr_tag;
      end
    end

    assign rd_valid[w] = vld_q[rd_idx];
    assign rd_tag[w]   = tag_mem[rd_idx];
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int SETS   = 128,
  parameter int IDX_W  = 7,
  parameter int WAYS   = 2,
  parameter int WAY_W  = 1,
  parameter int WSEL_W = 3,
  parameter int DW     = 32
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [WSEL_W-1:0]       rd_word,
  output logic [WAYS-1:0][DW-1:0] rd_data,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic [WSEL_W-1:0]       wr_word,
  input  logic [DW-1:0]           wr_data
);
  localparam int DEPTH = SETS * (2 ** WSEL_W);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) begin
        mem[{wr_idx, wr_word}] <= wr_data;
      end
    end

    assign rd_data[w] = mem[{rd_idx, rd_word}];
  end
endmodule

// File: rtl/vipt_repl.sv
module vipt_repl #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way
);
  logic [WAY_W-1:0] mru_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else if (upd_en) begin
      mru_q[upd_idx] <= upd_way;
    end
  end

  // next way after the most recently used one
  assign victim = (mru_q[rd_idx] == WAY_W'(WAYS - 1)) ? '0 : mru_q[rd_idx] + WAY_W'(1);
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int PAGE_W      = 12,
  parameter int PA_W        = 32,
  parameter int DW          = 32,
  parameter int WAYS        = 2,
  parameter int BLOCK_BYTES = 32,
  parameter int CACHE_BYTES = 8192
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [PAGE_W-1:0]      req_voff,
  input  logic [DW-1:0]          req_wdata,
  input  logic                   xlat_valid,
  input  logic [PA_W-PAGE_W-1:0] xlat_pfn,
  output logic                   xlat_stall,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic [DW-1:0]          resp_rdata,
  output logic                   mem_rd_req,
  output logic [PA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [DW-1:0]          mem_rd_data,
  output logic                   mem_wr_en,
  output logic [PA_W-1:0]        mem_wr_addr,
  output logic [DW-1:0]          mem_wr_data
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int SETS   = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WOFF_W = $clog2(DW / 8);
  localparam int WPB    = BLOCK_BYTES / (DW / 8);
  localparam int WSEL_W = $clog2(WPB);
  localparam int TAG_W  = PA_W - OFF_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  // index and block offset must come from untranslated bits
  if (IDX_W + OFF_W > PAGE_W) begin : g_bad_geometry
    $error("set index and block offset do not fit in the page offset");
  end

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  vipt_state_e state_q, state_d;
  logic [WSEL_W-1:0] beat_q, beat_d;
  logic resp_valid_q, resp_valid_d, resp_hit_q, resp_hit_d;
  logic rd_req_q, rd_req_d, wr_en_q, wr_en_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic rdata_en, cap_en;
  logic [PA_W-1:0] cap_paddr;
  logic [DW-1:0] cap_wdata;
  logic [WAY_W-1:0] cap_way;

  // lookup side, from the live request
  logic [PA_W-1:0]   lk_paddr;
  logic [IDX_W-1:0]  lk_idx;
  logic [WSEL_W-1:0] lk_word;
  logic [TAG_W-1:0]  lk_tag;
  logic              accept;
  assign lk_paddr = {xlat_pfn, req_voff};
  assign lk_idx   = req_voff[OFF_W +: IDX_W];
  assign lk_word  = req_voff[WOFF_W +: WSEL_W];
  assign lk_tag   = lk_paddr[PA_W-1 -: TAG_W];
  assign req_ready  = rst_ni && (state_q == ST_LOOKUP) && xlat_valid;
  assign xlat_stall = rst_ni && (state_q == ST_LOOKUP) && req_valid && !xlat_valid;
  assign accept     = req_valid && req_ready;

  logic [IDX_W-1:0]  cap_idx;
  logic [WSEL_W-1:0] cap_word;
  assign cap_idx  = cap_paddr[OFF_W +: IDX_W];
  assign cap_word = cap_paddr[WOFF_W +: WSEL_W];

  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][DW-1:0]    rd_data;
  logic [WAY_W-1:0]           victim;
  logic tag_we, dat_we, upd_en;
  logic [WAY_W-1:0]  dat_way, upd_way;
  logic [IDX_W-1:0]  dat_idx, upd_idx;
  logic [WSEL_W-1:0] dat_word;
  logic [DW-1:0]     dat_wdata;

  vipt_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_ni), .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .wr_en(tag_we), .wr_idx(cap_idx), .wr_way(cap_way), .wr_tag(cap_paddr[PA_W-1 -: TAG_W])
  );

  vipt_data_store #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W), .WSEL_W(WSEL_W), .DW(DW)) u_data (
    .clk(clk), .rd_idx(lk_idx), .rd_word(lk_word), .rd_data(rd_data),
    .wr_en(dat_we), .wr_idx(dat_idx), .wr_way(dat_way), .wr_word(dat_word), .wr_data(dat_wdata)
  );

  vipt_repl #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_repl (
    .clk(clk), .rst_n(rst_ni), .rd_idx(lk_idx), .victim(victim),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_way(upd_way)
  );

  // per-way physical tag compare
  logic [WAYS-1:0] way_hit;
  logic            lk_hit;
  logic [WAY_W-1:0] hit_way;
  logic [DW-1:0]    hit_data;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = rd_valid[w] && (rd_tag[w] == lk_tag);
  end
  assign lk_hit = |way_hit;

  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = rd_data[w];
      end
    end
  end

  // next state
  always_comb begin
    state_d      = state_q;
    beat_d       = beat_q;
    resp_valid_d = 1'b0;
    resp_hit_d   = 1'b0;
    rd_req_d     = 1'b0;
    wr_en_d      = 1'b0;
    rdata_en     = 1'b0;
    rdata_d      = hit_data;
    cap_en       = 1'b0;
    tag_we       = 1'b0;
    dat_we       = 1'b0;
    dat_way      = hit_way;
    dat_idx      = lk_idx;
    dat_word     = lk_word;
    dat_wdata    = req_wdata;
    upd_en       = 1'b0;
    upd_idx      = lk_idx;
    upd_way      = hit_way;
    unique case (state_q)
      ST_LOOKUP: begin
        if (accept) begin
          cap_en = 1'b1;
          if (req_write) begin
            wr_en_d      = 1'b1;
            resp_valid_d = 1'b1;
            resp_hit_d   = lk_hit;
            dat_we       = lk_hit;
            upd_en       = lk_hit;
          end else if (lk_hit) begin
            resp_valid_d = 1'b1;
            resp_hit_d   = 1'b1;
            rdata_en     = 1'b1;
            upd_en       = 1'b1;
          end else begin
            rd_req_d = 1'b1;
            beat_d   = '0;
            state_d  = ST_REFILL;
          end
        end
      end
      ST_REFILL: begin
        dat_way   = cap_way;
        dat_idx   = cap_idx;
        dat_word  = beat_q;
        dat_wdata = mem_rd_data;
        upd_idx   = cap_idx;
        upd_way   = cap_way;
        if (mem_rd_valid) begin
          dat_we = 1'b1;
          beat_d = beat_q + WSEL_W'(1);
          if (beat_q == cap_word) begin
            rdata_en = 1'b1;
            rdata_d  = mem_rd_data;
          end
          if (beat_q == WSEL_W'(WPB - 1)) begin
            tag_we       = 1'b1;
            upd_en       = 1'b1;
            resp_valid_d = 1'b1;
            state_d      = ST_LOOKUP;
          end
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_LOOKUP;
      beat_q       <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      rd_req_q     <= 1'b0;
      wr_en_q      <= 1'b0;
    end else begin
      state_q      <= state_d;
      beat_q       <= beat_d;
      resp_valid_q <= resp_valid_d;
      resp_hit_q   <= resp_hit_d;
      rd_req_q     <= rd_req_d;
      wr_en_q      <= wr_en_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      cap_paddr <= lk_paddr;
      cap_wdata <= req_wdata;
      cap_way   <= victim;
    end
    if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign resp_valid  = resp_valid_q;
  assign resp_hit    = resp_hit_q;
  assign resp_rdata  = rdata_q;
  assign mem_rd_req  = rd_req_q;
  assign mem_rd_addr = {cap_paddr[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wr_en   = wr_en_q;
  assign mem_wr_addr = cap_paddr;
  assign mem_wr_data = cap_wdata;
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic xlat_valid,
  input logic lk_hit,
  input logic resp_valid,
  input logic resp_hit,
  input logic mem_rd_req,
  input logic mem_wr_en
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_valid) |-> !req_ready); // R2

  AST_READ_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lk_hit && !req_write) |=> (resp_valid && resp_hit)); // R3

  AST_READ_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !lk_hit && !req_write) |=> (mem_rd_req && !resp_valid)); // R4

  AST_FETCH_RESP_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, resp_valid})); // R4

  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (mem_wr_en && resp_valid)); // R6

  AST_WRITE_MISS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !lk_hit) |=> (!mem_rd_req && !resp_hit)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !req_ready); // R10
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .xlat_valid(xlat_valid),
  .lk_hit(lk_hit),
  .resp_valid(resp_valid),
  .resp_hit(resp_hit),
  .mem_rd_req(mem_rd_req),
  .mem_wr_en(mem_wr_en)
);

// File: tb/vipt_l1_lookup_tb_top.sv
module vipt_l1_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [11:0] req_voff;
  logic [31:0] req_wdata;
  logic        xlat_valid, xlat_stall;
  logic [19:0] xlat_pfn;
  logic        resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic        mem_rd_req, mem_rd_valid, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;

  always #4 clk = ~clk;  // 125 MHz

  vipt_l1_lookup dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_voff(req_voff), .req_wdata(req_wdata),
    .xlat_valid(xlat_valid), .xlat_pfn(xlat_pfn), .xlat_stall(xlat_stall),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
  logic [31:0] mem_ovr [logic [31:0]];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (mem_ovr.exists(w)) return mem_ovr[w];
    return w ^ 32'hC3A5_0F0F;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory: burst responder, eight words per block
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        rd_cnt++;
        last_rd_addr = mem_rd_addr;
        @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_word(last_rd_addr + 32'(b * 4));
          @(negedge clk);
        end
        mem_rd_valid = 1'b0;
      end
    end
  end

  // memory: write-through monitor
  always @(negedge clk) begin
    if (mem_wr_en) begin
      wr_cnt++;
      last_wr_addr = mem_wr_addr;
      last_wr_data = mem_wr_data;
      mem_ovr[{mem_wr_addr[31:2], 2'b00}] = mem_wr_data;
    end
  end

  task automatic access(input bit wr, input logic [11:0] off, input logic [19:0] pfn,
                        input logic [31:0] wd, output bit hit, output logic [31:0] rd,
                        output int lat, output bit rdy_after);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_voff = off; req_wdata = wd;
    xlat_pfn = pfn; xlat_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    lat = 1;
    rdy_after = req_ready;
    while (!resp_valid && lat < 200) begin
      @(negedge clk); #1;
      lat++;
    end
    hit = resp_hit;
    rd  = resp_rdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] off;
    logic [19:0] pfn;
    logic [31:0] wd;
    logic        ehit;
    logic        efill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h064, 20'h00100, 32'h0,         1'b0, 1'b1},  // R4 cold miss
    '{1'b0, 12'h064, 20'h00100, 32'h0,         1'b1, 1'b0},  // R3 hit
    '{1'b0, 12'h070, 20'h00100, 32'h0,         1'b1, 1'b0},  // R1 other word, same block
    '{1'b1, 12'h068, 20'h00100, 32'hDEADBEEF,  1'b1, 1'b0},  // R6 write hit
    '{1'b0, 12'h068, 20'h00100, 32'h0,         1'b1, 1'b0},  // R6 patched word
    '{1'b0, 12'h064, 20'h00200, 32'h0,         1'b0, 1'b1},  // R8 other frame misses
    '{1'b0, 12'h064, 20'h00100, 32'h0,         1'b1, 1'b0},  // R8 old line kept, R5 touch
    '{1'b0, 12'h064, 20'h00300, 32'h0,         1'b0, 1'b1},  // R5 evicts frame 200
    '{1'b0, 12'h064, 20'h00100, 32'h0,         1'b1, 1'b0},  // R5 frame 100 survived
    '{1'b0, 12'h064, 20'h00200, 32'h0,         1'b0, 1'b1},  // R5 frame 200 was gone
    '{1'b1, 12'h080, 20'h00400, 32'h12345678,  1'b0, 1'b0},  // R7 write miss
    '{1'b0, 12'h080, 20'h00400, 32'h0,         1'b0, 1'b1},  // R7 no allocate
    '{1'b0, 12'h09C, 20'h00400, 32'h0,         1'b1, 1'b0},  // R4 last word of block
    '{1'b0, 12'h064, 20'h00300, 32'h0,         1'b0, 1'b1}   // R5 frame 300 was evicted
  };

  bit          hit, rdy;
  logic [31:0] rd, exp_rd;
  int          lat, rc0, wc0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_voff = '0;
    req_wdata = '0; xlat_valid = 1'b1; xlat_pfn = '0;
    repeat (3) @(negedge clk);
    // R9 idle outputs during reset
    chk("R9 resp_valid in reset", 32'(resp_valid), 32'd0);
    chk("R9 mem_rd_req in reset", 32'(mem_rd_req), 32'd0);
    chk("R9 mem_wr_en in reset", 32'(mem_wr_en), 32'd0);
    chk("R9 req_ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ready after reset", 32'(req_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      rc0 = rd_cnt; wc0 = wr_cnt;
      exp_rd = mem_word({VECS[i].pfn, VECS[i].off});
      access(VECS[i].wr, VECS[i].off, VECS[i].pfn, VECS[i].wd, hit, rd, lat, rdy);
      chk($sformatf("R3 hit flag v%0d", i), 32'(hit), 32'(VECS[i].ehit));
      chk($sformatf("R4 refill count v%0d", i), 32'(rd_cnt - rc0), 32'(VECS[i].efill));
      if (VECS[i].efill) begin
        chk($sformatf("R1 R4 refill address v%0d", i), last_rd_addr,
            {VECS[i].pfn, VECS[i].off[11:5], 5'b0});
        chk($sformatf("R10 ready low in refill v%0d", i), 32'(rdy), 32'd0);
      end
      chk($sformatf("R6 write forward count v%0d", i), 32'(wr_cnt - wc0), 32'(VECS[i].wr));
      if (VECS[i].wr) begin
        chk($sformatf("R6 write address v%0d", i), last_wr_addr, {VECS[i].pfn, VECS[i].off});
        chk($sformatf("R6 write data v%0d", i), last_wr_data, VECS[i].wd);
      end else begin
        chk($sformatf("R3 read data v%0d", i), rd, exp_rd);
        if (VECS[i].ehit) chk($sformatf("R3 hit latency v%0d", i), 32'(lat), 32'd1);
      end
    end

    // R2 stall without translation; frame 300 now resident in set 3
    rc0 = rd_cnt; wc0 = wr_cnt;
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_voff = 12'h064; xlat_pfn = 20'h00300;
    xlat_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R2 stall flag", 32'(xlat_stall), 32'd1);
      chk("R2 not ready", 32'(req_ready), 32'd0);
      chk("R2 no response", 32'(resp_valid), 32'd0);
    end
    chk("R2 no memory read", 32'(rd_cnt - rc0), 32'd0);
    chk("R2 no memory write", 32'(wr_cnt - wc0), 32'd0);
    xlat_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    chk("R2 resumes as hit", {30'd0, resp_valid, resp_hit}, 32'd3);
    chk("R2 resumed data", resp_rdata, mem_word({20'h00300, 12'h064}));

    // R9 reset clears valid lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rc0 = rd_cnt;
    access(1'b0, 12'h064, 20'h00300, 32'h0, hit, rd, lat, rdy);
    chk("R9 miss after reset", 32'(hit), 32'd0);
    chk("R9 refill after reset", 32'(rd_cnt - rc0), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule